// File: doc/BRIEF.md
# Snoop and DVM Enable Controller

This block decides, per coherent slave interface, whether snoop requests and DVM messages may be sent to it. Software programs a small control word per interface. A hardware block input per interface can veto both kinds of traffic regardless of what software wrote. The block turns these into the effective enable vectors that the snoop dispatcher and the DVM broadcaster use. It also runs the DVM broadcast itself, fanning one message out to every interface whose effective DVM enable is set and collecting their acknowledges.

An enable change is not applied at once. It waits until the interface has no snoop or DVM traffic in flight, which the block learns from a per-interface outstanding count. Until then a pending flag in the status word stays set. Software polls that flag to learn when a change has taken effect, which it needs before it powers a master down or lets a master start caching shareable data.

Each per-interface controller is a two-state machine. In `IF_SETTLED` the applied enables equal the programmed ones. On a write that changes an enable, it takes the transition *change-written* to `IF_DRAIN`. It takes the transition *drained* back to `IF_SETTLED` in a cycle where the outstanding count is zero and no new changing write arrives, and it applies the programmed value on that edge. The broadcaster has three states. In `BC_IDLE` it takes *start* to `BC_ISSUE` when targets exist, or *skip* straight to `BC_DONE` when none are enabled. In `BC_ISSUE` it takes *all-acked* to `BC_DONE`. From `BC_DONE` it takes *retire* back to `BC_IDLE` after one cycle.

Top module: `snp_dvm_enable_ctrl`

## Requirements
- R1: Out of reset every programmed enable, every effective enable output, the status word and `dvm_issue` are all 0.
- R2: The control word of interface i sits at word address i. Bit 0 is the snoop enable and bit 1 is the DVM enable, both readable and writable. All other bits read 0, except bit 29.
- R3: Bit 29 of a control word is read-only. It reads 1 when that interface is under hardware control, which means its latched block input is 1. Writes to bit 29 are ignored.
- R4: An effective enable output is the applied enable bit ANDed with the inverse of the latched block input. A blocked interface never shows an effective enable.
- R5: The `hw_block` inputs are captured only while `rst_n` is low. Changes after reset deasserts have no effect.
- R6: A write that changes an interface's snoop or DVM bit sets its pending flag. A write that leaves both bits unchanged does not set it.
- R7: While the interface's outstanding count is nonzero, the pending flag stays set and the effective enables keep their old value. On the first edge with a zero count, the new value is applied and the pending flag clears.
- R8: Status lives at word address N_IF. Its bit 0 is the OR of all pending flags, and all its other bits read 0. Reads of unmapped addresses return 0. Read data appears one cycle after `reg_rd_en`.
- R9: A `dvm_start` in idle snapshots the effective DVM enables as targets. `dvm_issue` then shows the targets that have not yet acknowledged. `dvm_done` pulses for one cycle, in the cycle after the last acknowledge.
- R10: A `dvm_start` when no interface has an effective DVM enable skips issuing: `dvm_done` pulses in the next cycle and `dvm_issue` stays 0.
- R11: A `dvm_start` while a broadcast is in progress is ignored and does not begin a second broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| hw_block | input | N_IF | Per-interface hardware block, sampled during reset |
| outst_cnt | input | N_IF*CNT_W | Per-interface outstanding snoop/DVM count |
| snoop_en_eff | output | N_IF | Effective snoop enable per interface |
| dvm_en_eff | output | N_IF | Effective DVM enable per interface |
| dvm_start | input | 1 | Request to broadcast one DVM message |
| dvm_ack | input | N_IF | Per-target acknowledge |
| dvm_issue | output | N_IF | Targets still awaiting acknowledge |
| dvm_busy | output | 1 | Broadcast in progress |
| dvm_done | output | 1 | One-cycle broadcast completion pulse |

## Verification
The bench builds the block with N_IF = 4, CNT_W = 3 and ADDR_W = 4. With these values the status word sits at address 4, and addresses 5 to 15 fall in the unmapped range. Four interfaces are enough to hold a blocked interface, one waiting on a nonzero count, and both DVM-enabled and DVM-disabled targets all at once. That lets one broadcast check skipping and partial acknowledges together. The 3-bit count lets a held count of 5 keep an interface pending across several polls.

// File: rtl/snp_dvm_pkg.sv
package snp_dvm_pkg;
    typedef enum logic {
        IF_SETTLED,
        IF_DRAIN
    } if_state_e;

    typedef enum logic [1:0] {
        BC_IDLE,
        BC_ISSUE,
        BC_DONE
    } bc_state_e;

    localparam int SNP_BIT   = 0;
    localparam int DVM_BIT   = 1;
    localparam int HWCTL_BIT = 29;
    localparam int REG_W     = 32;
endpackage

// File: rtl/snp_if_ctrl.sv
module snp_if_ctrl
    import snp_dvm_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             wr_snp,
    input  logic             wr_dvm,
    input  logic             blocked,
    input  logic [CNT_W-1:0] outst,
    output logic             prog_snp,
    output logic             prog_dvm,
    output logic             eff_snp,
    output logic             eff_dvm,
    output logic             pending
);
    if_state_e state_q, state_d;
    logic      app_snp_q, app_dvm_q;
    logic      changed, idle_cnt;

    assign changed  = wr_hit && ({wr_snp, wr_dvm} != {prog_snp, prog_dvm});
    assign idle_cnt = (outst == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IF_SETTLED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IF_SETTLED: if (changed) state_d = IF_DRAIN;
            IF_DRAIN:   if (idle_cnt && !changed) state_d = IF_SETTLED;
            default:    state_d = IF_SETTLED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_snp  <= 1'b0;
            prog_dvm  <= 1'b0;
            app_snp_q <= 1'b0;
            app_dvm_q <= 1'b0;
        end else begin
            if (wr_hit) begin
                prog_snp <= wr_snp;
                prog_dvm <= wr_dvm;
            end
            if (state_q == IF_DRAIN && idle_cnt) begin
                app_snp_q <= prog_snp;
                app_dvm_q <= prog_dvm;
            end
        end
    end

    always_comb begin
        pending = (state_q == IF_DRAIN);
        eff_snp = app_snp_q && !blocked;
        eff_dvm = app_dvm_q && !blocked;
    end

    assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !idle_cnt) |=> (pending && $stable(app_snp_q) && $stable(app_dvm_q)));

    assert_settled_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> (app_snp_q == $past(prog_snp) && app_dvm_q == $past(prog_dvm)));
endmodule

// File: rtl/snp_dvm_bcast.sv
module snp_dvm_bcast
    import snp_dvm_pkg::*;
#(
    parameter int N_IF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N_IF-1:0] targets,
    input  logic [N_IF-1:0] ack,
    output logic [N_IF-1:0] issue,
    output logic            busy,
    output logic            done
);
    bc_state_e       state_q, state_d;
    logic [N_IF-1:0] wait_q, wait_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BC_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        unique case (state_q)
            BC_IDLE: begin
                if (start) begin
                    wait_d  = targets;
                    state_d = (targets == '0) ? BC_DONE : BC_ISSUE;
                end
            end
            BC_ISSUE: begin
                wait_d = wait_q & ~ack;
                if ((wait_q & ~ack) == '0) state_d = BC_DONE;
            end
            BC_DONE: begin
                wait_d  = '0;
                state_d = BC_IDLE;
            end
            default: state_d = BC_IDLE;
        endcase
    end

    always_comb begin
        issue = (state_q == BC_ISSUE) ? wait_q : '0;
        busy  = (state_q == BC_ISSUE);
        done  = (state_q == BC_DONE);
    end

    assert_issue_drops_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(issue) & ~issue) & ~$past(ack)) == '0) || $past(state_q == BC_IDLE));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((issue & ~$past(issue)) == '0));
endmodule

// File: rtl/snp_dvm_enable_ctrl.sv
module snp_dvm_enable_ctrl
    import snp_dvm_pkg::*;
#(
    parameter int N_IF   = 4,
    parameter int CNT_W  = 3,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [N_IF-1:0]       hw_block,
    input  logic [N_IF*CNT_W-1:0] outst_cnt,
    output logic [N_IF-1:0]       snoop_en_eff,
    output logic [N_IF-1:0]       dvm_en_eff,
    input  logic                  dvm_start,
    input  logic [N_IF-1:0]       dvm_ack,
    output logic [N_IF-1:0]       dvm_issue,
    output logic                  dvm_busy,
    output logic                  dvm_done
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(N_IF);

    logic [N_IF-1:0]  mask_q;
    logic [N_IF-1:0]  prog_snp, prog_dvm, pend;
    logic [REG_W-1:0] rd_d;

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= hw_block;
    end

    for (genvar gi = 0; gi < N_IF; gi++) begin : g_if
        snp_if_ctrl #(.CNT_W(CNT_W)) u_if (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (reg_wr_en && (reg_addr == ADDR_W'(gi))),
            .wr_snp   (reg_wdata[SNP_BIT]),
            .wr_dvm   (reg_wdata[DVM_BIT]),
            .blocked  (mask_q[gi]),
            .outst    (outst_cnt[gi*CNT_W +: CNT_W]),
            .prog_snp (prog_snp[gi]),
            .prog_dvm (prog_dvm[gi]),
            .eff_snp  (snoop_en_eff[gi]),
            .eff_dvm  (dvm_en_eff[gi]),
            .pending  (pend[gi])
        );
    end

    snp_dvm_bcast #(.N_IF(N_IF)) u_bcast (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dvm_start),
        .targets (dvm_en_eff),
        .ack     (dvm_ack),
        .issue   (dvm_issue),
        .busy    (dvm_busy),
        .done    (dvm_done)
    );

    always_comb begin
        rd_d = '0;
        for (int i = 0; i < N_IF; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                rd_d[SNP_BIT]   = prog_snp[i];
                rd_d[DVM_BIT]   = prog_dvm[i];
                rd_d[HWCTL_BIT] = mask_q[i];
            end
        end
        if (reg_addr == STATUS_ADDR) rd_d[0] = |pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd_en) begin
            reg_rdata <= rd_d;
        end
    end

    assert_blocked_never_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((snoop_en_eff | dvm_en_eff) & mask_q) == '0);

    assert_mask_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mask_q));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr > STATUS_ADDR) |=> (reg_rdata == '0));

    assert_targets_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dvm_start) && !$past(dvm_busy) && !$past(dvm_done)) |->
            (dvm_issue == $past(dvm_en_eff)));
endmodule

// File: tb/snp_dvm_enable_ctrl_bench.sv
`timescale 1ns/1ps
module snp_dvm_enable_ctrl_bench;
    localparam int N_IF   = 4;
    localparam int CNT_W  = 3;
    localparam int ADDR_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [ADDR_W-1:0]     reg_addr = '0;
    logic [31:0]           reg_wdata = '0;
    logic [31:0]           reg_rdata;
    logic [N_IF-1:0]       hw_block = '0;
    logic [N_IF*CNT_W-1:0] outst_cnt = '0;
    logic [N_IF-1:0]       snoop_en_eff, dvm_en_eff;
    logic                  dvm_start = 1'b0;
    logic [N_IF-1:0]       dvm_ack = '0;
    logic [N_IF-1:0]       dvm_issue;
    logic                  dvm_busy, dvm_done;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    snp_dvm_enable_ctrl #(.N_IF(N_IF), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_snp_dvm_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_block(hw_block), .outst_cnt(outst_cnt), .snoop_en_eff(snoop_en_eff),
        .dvm_en_eff(dvm_en_eff), .dvm_start(dvm_start), .dvm_ack(dvm_ack),
        .dvm_issue(dvm_issue), .dvm_busy(dvm_busy), .dvm_done(dvm_done)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        rd_seen <= reg_rd_en;
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            report();
        end
    end

    // monitor: read data is valid after the edge that sampled reg_rd_en
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-underflow", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_addr  = ADDR_W'(a);
        reg_rd_en = 1'b1;
        tick();
        reg_rd_en = 1'b0;
    endtask

    initial begin
        hw_block = 4'b0100;
        tick(4);
        rst_n = 1'b1;
        tick();
        hw_block = 4'b0001;                   // R5: change after reset must be ignored
        check("R1 snoop_en_eff", 32'(snoop_en_eff), 32'd0);
        check("R1 dvm_en_eff", 32'(dvm_en_eff), 32'd0);
        check("R1 dvm_issue", 32'(dvm_issue), 32'd0);
        rd(0, 32'h0, "R1 ctrl0 reset");
        rd(2, 32'h2000_0000, "R3 ctrl2 hw flag");
        rd(0, 32'h0, "R5 ctrl0 flag stays clear");
        rd(4, 32'h0, "R1 status reset");
        rd(7, 32'h0, "R8 unmapped read");

        wr(0, 32'hFFFF_FFFF);                 // R2/R3: only bits 0,1 stored
        rd(4, 32'h1, "R6 status pending after change");
        check("R4 eff snoop0 applied", 32'(snoop_en_eff[0]), 32'd1);
        check("R4 eff dvm0 applied", 32'(dvm_en_eff[0]), 32'd1);
        rd(0, 32'h3, "R2 ctrl0 readback");

        outst_cnt[1*CNT_W +: CNT_W] = 3'd5;
        wr(1, 32'h1);
        tick(3);
        rd(4, 32'h1, "R7 pending held while outstanding");
        check("R7 eff snoop1 held old", 32'(snoop_en_eff[1]), 32'd0);
        outst_cnt[1*CNT_W +: CNT_W] = 3'd0;
        tick(2);
        check("R7 eff snoop1 applied after drain", 32'(snoop_en_eff[1]), 32'd1);
        rd(4, 32'h0, "R7 status clear after drain");
        wr(1, 32'h1);
        rd(4, 32'h0, "R6 unchanged write no pending");

        wr(2, 32'h3);
        tick(2);
        rd(2, 32'h2000_0003, "R3 ctrl2 readback with flag");
        check("R4 blocked if2 snoop", 32'(snoop_en_eff[2]), 32'd0);
        check("R4 blocked if2 dvm", 32'(dvm_en_eff[2]), 32'd0);
        check("R5 if0 still enabled", 32'(snoop_en_eff[0]), 32'd1);

        wr(3, 32'h2);
        tick(2);
        check("R4 dvm vector", 32'(dvm_en_eff), 32'h9);
        dvm_start = 1'b1;
        tick();
        dvm_start = 1'b0;
        check("R9 issue targets", 32'(dvm_issue), 32'h9);
        check("R9 busy", 32'(dvm_busy), 32'd1);
        dvm_start = 1'b1;                     // R11: must be ignored
        dvm_ack = 4'b0001;
        tick();
        dvm_start = 1'b0;
        check("R9 issue after first ack", 32'(dvm_issue), 32'h8);
        check("R9 no done yet", 32'(dvm_done), 32'd0);
        dvm_ack = 4'b1000;
        tick();
        dvm_ack = 4'b0000;
        check("R9 done pulse", 32'(dvm_done), 32'd1);
        check("R9 issue cleared", 32'(dvm_issue), 32'd0);
        tick();
        check("R11 no restart done", 32'(dvm_done), 32'd0);
        check("R11 no restart busy", 32'(dvm_busy), 32'd0);

        wr(0, 32'h1);
        wr(3, 32'h0);
        tick(2);
        check("R10 no dvm targets", 32'(dvm_en_eff), 32'h0);
        dvm_start = 1'b1;
        tick();
        dvm_start = 1'b0;
        check("R10 done immediately", 32'(dvm_done), 32'd1);
        check("R10 nothing issued", 32'(dvm_issue), 32'd0);
        tick(3);
        if (exp_q.size() != 0) check("scoreboard-leftover", 32'(exp_q.size()), 32'd0);
        report();
    end
endmodule